// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a small register window that lets a host processor hand a command to an embedded controller and collect the answer. The host first fills a 16-byte payload area with 32-bit writes, then writes a command word. That write marks the mailbox busy and rings a one-cycle doorbell toward the controller. The controller reads the latched command word and the payload words, fills a 16-byte answer area, and pulses a done strobe carrying an error bit, an error code and an initiator tag.

On done, busy drops and the error fields are captured into the status word. If the command asked for interrupt-on-completion, the block pulses an interrupt line to the host for one cycle. It also sets a sticky interrupt flag in status, which the host clears by writing 1 to that bit. A host that does not use interrupts polls status until busy is clear and then checks the error bit. A second command written while the first is still pending is refused, and the refusal is reported as an error.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, status (offset 0x04) reads 0, and neither the doorbell nor the host interrupt is asserted.
- R2: A write to offset 0x00 while busy is clear is accepted. In the next cycle busy (status bit 0) is 1, the doorbell is high for exactly that one cycle, `ctl_cmd` shows the written word, status bits 7:4 show command bits 15:12, and the error bit and any earlier overrun are cleared.
- R3: A 32-bit host write to offset 0x80+4k stores payload word k. Presenting index k on `ctl_pay_idx` yields that word on `ctl_pay_word` one cycle later.
- R4: A controller write of answer word k is read by the host at offset 0x90+4k. A byte read (`h_rd_byte`=1) returns byte `addr[1:0]` of the word in bits 7:0, with byte 0 in bits 7:0 of the word, and zeros in bits 31:8.
- R5: A done pulse while busy clears busy and captures the controller's error bit into status bit 1, its error code into bits 23:16 and its initiator tag into bits 15:8.
- R6: If command bit 8 (interrupt-on-completion) was set, a done pulse while busy gives a one-cycle `host_irq` pulse in the next cycle and sets status bit 2. If bit 8 was clear, neither happens.
- R7: A host write to status with bit 2 set clears the interrupt flag, and a write with bit 2 clear leaves it unchanged. If a completion sets the flag in the same cycle, the flag ends up set.
- R8: A command write while busy is ignored (no doorbell, `ctl_cmd` unchanged) and sets the error bit at once. The error bit stays set through the following completion, even one in the same cycle, whatever error the controller reports.
- R9: A done pulse while busy is clear changes no status field and produces no host interrupt.
- R10: Each read gives `h_rvalid` and its data in the next cycle, showing status as it stood in the read cycle. Reads of offsets 0x00, 0x80 and any unmapped offset return 0, and `h_rdata` is 0 whenever `h_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr_en | input | 1 | Host write strobe |
| h_rd_en | input | 1 | Host read strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rd_byte | input | 1 | Byte-sized read when 1 |
| h_rdata | output | 32 | Host read data |
| h_rvalid | output | 1 | Read data valid |
| host_irq | output | 1 | Completion interrupt pulse to host |
| ctl_doorbell | output | 1 | New-command pulse to controller |
| ctl_cmd | output | 32 | Latched command word |
| ctl_pay_idx | input | IDX_W | Payload word index |
| ctl_pay_word | output | 32 | Payload word at index, one cycle later |
| ctl_rsp_we | input | 1 | Answer word write strobe |
| ctl_rsp_idx | input | IDX_W | Answer word index |
| ctl_rsp_word | input | 32 | Answer word data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Completion error bit |
| ctl_err_code | input | 8 | Completion error code |
| ctl_init_id | input | 8 | Initiator tag reported with completion |

## Verification
Two pairs of events are made to fall on the same clock edge. In the first, the controller's done pulse for an interrupt-on-completion command lands together with a host status write that clears the interrupt flag; the flag must end up set, so the next completion interrupt cannot be lost. In the second, done lands together with a refused second command write; busy must drop while the error bit is forced on and the latched command stays unchanged. Both outcomes are judged by a status read whose expected value is worked out by hand, and by a cycle model in the bench that is compared with the outputs on every clock.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // host-visible byte offsets
  localparam int OFF_CMD  = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_WBUF = 'h80;
  localparam int OFF_RBUF = 'h90;

  // command word bit positions
  localparam int CMD_IOC_BIT = 8;
  localparam int CMD_ID_LSB  = 12;
  localparam int STAT_IRQ_BIT = 2;

  typedef struct packed {
    logic [7:0] spare_hi;
    logic [7:0] code;
    logic [7:0] init;
    logic [3:0] id;
    logic       spare_lo;
    logic       irq;
    logic       err;
    logic       busy;
  } mbx_status_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_STAT = 2'd1,
    SRC_RBUF = 2'd2
  } mbx_src_e;
endpackage

// File: rtl/mbx_buffer.sv
// Word storage with one write port and one registered read port
// (read-before-write on a collision), shaped for block RAM inference.
module mbx_buffer #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/mbx_ctrl.sv
// Busy / error / interrupt bookkeeping of the mailbox.
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_data,
  input  logic        irq_clr,
  input  logic        done,
  input  logic        done_err,
  input  logic [7:0]  done_code,
  input  logic [7:0]  done_init,
  output mbx_status_t status,
  output logic [31:0] cmd_word,
  output logic        doorbell,
  output logic        host_irq
);
  logic       busy_q, err_q, ovr_q, irq_q, ioc_q;
  logic [3:0] id_q;
  logic [7:0] code_q, init_q;
  logic [31:0] cmd_q;
  logic       bell_q, hirq_q;

  logic accept, overrun, finish;
  assign accept  = cmd_wr & ~busy_q;
  assign overrun = cmd_wr &  busy_q;
  assign finish  = done   &  busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
      ioc_q  <= 1'b0;
      id_q   <= '0;
      code_q <= '0;
      init_q <= '0;
      cmd_q  <= '0;
      bell_q <= 1'b0;
      hirq_q <= 1'b0;
    end else begin
      bell_q <= accept;
      hirq_q <= finish & ioc_q;

      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= cmd_data;
        ioc_q  <= cmd_data[CMD_IOC_BIT];
        id_q   <= cmd_data[CMD_ID_LSB +: 4];
        err_q  <= 1'b0;
        ovr_q  <= 1'b0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= done_err | ovr_q;
        code_q <= done_code;
        init_q <= done_init;
      end

      // a refused command forces the error flag, even on a completion edge
      if (overrun) begin
        ovr_q <= 1'b1;
        err_q <= 1'b1;
      end

      // completion setting the flag wins over a host clear
      if (finish & ioc_q)  irq_q <= 1'b1;
      else if (irq_clr)    irq_q <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status.busy     = busy_q;
    status.err      = err_q;
    status.irq      = irq_q;
    status.id       = id_q;
    status.init     = init_q;
    status.code     = code_q;
  end

  assign cmd_word = cmd_q;
  assign doorbell = bell_q;
  assign host_irq = hirq_q;
endmodule

// File: rtl/mbx_rdpath.sv
// Host read return path: registered source select, status snapshot and byte lane.
module mbx_rdpath
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  mbx_src_e    src,
  input  logic [1:0]  lane,
  input  logic        byte_mode,
  input  mbx_status_t status,
  input  logic [31:0] rbuf_word,
  output logic [31:0] rdata,
  output logic        rvalid
);
  mbx_src_e    src_q;
  logic [1:0]  lane_q;
  logic        byte_q;
  logic [31:0] stat_q;
  logic        valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= SRC_NONE;
      lane_q  <= '0;
      byte_q  <= 1'b0;
      stat_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      src_q   <= rd_en ? src : SRC_NONE;
      lane_q  <= lane;
      byte_q  <= byte_mode;
      stat_q  <= status;
      valid_q <= rd_en;
    end
  end

  logic [31:0] word;
  always_comb begin
    case (src_q)
      SRC_STAT: word = stat_q;
      SRC_RBUF: word = rbuf_word;
      default:  word = '0;
    endcase
  end

  logic [7:0] lanes [4];
  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign rdata  = byte_q ? {24'h0, lanes[lane_q]} : word;
  assign rvalid = valid_q;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int ADDR_W    = 8,
  localparam int WORDS    = BUF_BYTES / 4,
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr_en,
  input  logic              h_rd_en,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [31:0]       h_wdata,
  input  logic              h_rd_byte,
  output logic [31:0]       h_rdata,
  output logic              h_rvalid,
  output logic              host_irq,
  output logic              ctl_doorbell,
  output logic [31:0]       ctl_cmd,
  input  logic [IDX_W-1:0]  ctl_pay_idx,
  output logic [31:0]       ctl_pay_word,
  input  logic              ctl_rsp_we,
  input  logic [IDX_W-1:0]  ctl_rsp_idx,
  input  logic [31:0]       ctl_rsp_word,
  input  logic              ctl_done,
  input  logic              ctl_err,
  input  logic [7:0]        ctl_err_code,
  input  logic [7:0]        ctl_init_id
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_WBUF = ADDR_W'(OFF_WBUF);
  localparam logic [ADDR_W-1:0] A_RBUF = ADDR_W'(OFF_RBUF);
  localparam logic [ADDR_W-1:0] A_SPAN = ADDR_W'(BUF_BYTES);

  // ---------------- address decode ----------------
  logic              sel_cmd, sel_stat, in_wbuf, in_rbuf;
  logic [ADDR_W-1:0] wb_off, rb_off;
  logic [IDX_W-1:0]  wb_idx, rb_idx;

  assign sel_cmd  = (h_addr == A_CMD);
  assign sel_stat = (h_addr == A_STAT);
  assign wb_off   = h_addr - A_WBUF;
  assign rb_off   = h_addr - A_RBUF;
  assign in_wbuf  = (h_addr >= A_WBUF) && (wb_off < A_SPAN);
  assign in_rbuf  = (h_addr >= A_RBUF) && (rb_off < A_SPAN);
  assign wb_idx   = IDX_W'(wb_off >> 2);
  assign rb_idx   = IDX_W'(rb_off >> 2);

  mbx_src_e rd_src;
  always_comb begin
    if (sel_stat)     rd_src = SRC_STAT;
    else if (in_rbuf) rd_src = SRC_RBUF;
    else              rd_src = SRC_NONE;
  end

  // ---------------- control state ----------------
  mbx_status_t stat_w;
  logic        busy_w, err_w, irqf_w;

  mbx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (h_wr_en & sel_cmd),
    .cmd_data  (h_wdata),
    .irq_clr   (h_wr_en & sel_stat & h_wdata[STAT_IRQ_BIT]),
    .done      (ctl_done),
    .done_err  (ctl_err),
    .done_code (ctl_err_code),
    .done_init (ctl_init_id),
    .status    (stat_w),
    .cmd_word  (ctl_cmd),
    .doorbell  (ctl_doorbell),
    .host_irq  (host_irq)
  );

  assign busy_w = stat_w.busy;
  assign err_w  = stat_w.err;
  assign irqf_w = stat_w.irq;

  // ---------------- payload (host -> controller) ----------------
  mbx_buffer #(.WORDS(WORDS), .DW(32)) u_wbuf (
    .clk     (clk),
    .we      (h_wr_en & in_wbuf),
    .wr_idx  (wb_idx),
    .wr_data (h_wdata),
    .rd_idx  (ctl_pay_idx),
    .rd_data (ctl_pay_word)
  );

  // ---------------- answer (controller -> host) ----------------
  logic [31:0] rbuf_q;

  mbx_buffer #(.WORDS(WORDS), .DW(32)) u_rbuf (
    .clk     (clk),
    .we      (ctl_rsp_we),
    .wr_idx  (ctl_rsp_idx),
    .wr_data (ctl_rsp_word),
    .rd_idx  (rb_idx),
    .rd_data (rbuf_q)
  );

  // ---------------- host read return ----------------
  mbx_rdpath u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (h_rd_en),
    .src       (rd_src),
    .lane      (h_addr[1:0]),
    .byte_mode (h_rd_byte),
    .status    (stat_w),
    .rbuf_word (rbuf_q),
    .rdata     (h_rdata),
    .rvalid    (h_rvalid)
  );
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              h_wr_en,
  input logic              h_rd_en,
  input logic [ADDR_W-1:0] h_addr,
  input logic              h_rvalid,
  input logic              host_irq,
  input logic              ctl_doorbell,
  input logic [31:0]       ctl_cmd,
  input logic              ctl_done,
  input logic              busy,
  input logic              err_flag,
  input logic              irq_flag
);
  logic cmd_wr;
  assign cmd_wr = h_wr_en && (h_addr == '0);

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !busy) |=> (busy && ctl_doorbell));

  assert_bell_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_doorbell |=> !ctl_doorbell);

  assert_finish_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_done && busy) |=> !busy);

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    host_irq |=> !host_irq);

  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> irq_flag);

  assert_overrun_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy && !ctl_done) |=> (busy && err_flag && $stable(ctl_cmd) && !ctl_doorbell));

  assert_idle_done_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl_done && !busy && !cmd_wr) |=> (!busy && !host_irq && $stable(err_flag)));

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    h_rd_en |=> h_rvalid);

  assert_no_rvalid_R10: assert property (@(posedge clk) disable iff (rst)
    !h_rd_en |=> !h_rvalid);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .h_wr_en      (h_wr_en),
  .h_rd_en      (h_rd_en),
  .h_addr       (h_addr),
  .h_rvalid     (h_rvalid),
  .host_irq     (host_irq),
  .ctl_doorbell (ctl_doorbell),
  .ctl_cmd      (ctl_cmd),
  .ctl_done     (ctl_done),
  .busy         (busy_w),
  .err_flag     (err_w),
  .irq_flag     (irqf_w)
);

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr_en = 0, h_rd_en = 0, h_rd_byte = 0;
  logic [7:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_rvalid, host_irq, ctl_doorbell;
  logic [31:0] ctl_cmd, ctl_pay_word;
  logic [1:0]  ctl_pay_idx = '0, ctl_rsp_idx = '0;
  logic        ctl_rsp_we = 0, ctl_done = 0, ctl_err = 0;
  logic [31:0] ctl_rsp_word = '0;
  logic [7:0]  ctl_err_code = '0, ctl_init_id = '0;

  always #4 clk = ~clk;

  ipc_mailbox u_dut (
    .clk(clk), .rst(rst), .h_wr_en(h_wr_en), .h_rd_en(h_rd_en), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rd_byte(h_rd_byte), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
    .host_irq(host_irq), .ctl_doorbell(ctl_doorbell), .ctl_cmd(ctl_cmd),
    .ctl_pay_idx(ctl_pay_idx), .ctl_pay_word(ctl_pay_word), .ctl_rsp_we(ctl_rsp_we),
    .ctl_rsp_idx(ctl_rsp_idx), .ctl_rsp_word(ctl_rsp_word), .ctl_done(ctl_done),
    .ctl_err(ctl_err), .ctl_err_code(ctl_err_code), .ctl_init_id(ctl_init_id)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_busy, m_err, m_ovr, m_irq, m_ioc, m_bell, m_hirq, m_rvalid;
  int          m_id, m_code, m_init;
  logic [31:0] m_cmd, m_rdata, m_payw;
  logic [31:0] m_pay [4];
  logic [31:0] m_rsp [4];

  always @(posedge clk) begin
    logic [31:0] st, w;
    bit acc, ovr, fin;
    int a;
    m_payw = m_pay[ctl_pay_idx];
    if (rst) begin
      m_busy = 0; m_err = 0; m_ovr = 0; m_irq = 0; m_ioc = 0;
      m_bell = 0; m_hirq = 0; m_rvalid = 0;
      m_id = 0; m_code = 0; m_init = 0; m_cmd = 0; m_rdata = 0;
    end else begin
      a  = h_addr;
      st = (m_code << 16) | (m_init << 8) | (m_id << 4) | (m_irq << 2) | (m_err << 1) | m_busy;
      m_rvalid = h_rd_en;
      w = 0;
      if (h_rd_en) begin
        if (a == 4) w = st;
        else if (a >= 'h90 && a < 'hA0) w = m_rsp[(a - 'h90) / 4];
        if (h_rd_byte) w = (w >> (8 * (a % 4))) & 32'hFF;
      end
      m_rdata = w;
      if (h_wr_en && a >= 'h80 && a < 'h90) m_pay[(a - 'h80) / 4] = h_wdata;
      if (ctl_rsp_we) m_rsp[ctl_rsp_idx] = ctl_rsp_word;
      acc = h_wr_en && a == 0 && !m_busy;
      ovr = h_wr_en && a == 0 && m_busy;
      fin = ctl_done && m_busy;
      m_bell = acc;
      m_hirq = fin && m_ioc;
      if (fin && m_ioc) m_irq = 1;
      else if (h_wr_en && a == 4 && h_wdata[2]) m_irq = 0;
      if (acc) begin
        m_busy = 1; m_cmd = h_wdata; m_ioc = h_wdata[8]; m_id = h_wdata[15:12];
        m_err = 0; m_ovr = 0;
      end else if (fin) begin
        m_busy = 0; m_err = ctl_err | m_ovr; m_code = ctl_err_code; m_init = ctl_init_id;
      end
      if (ovr) begin m_ovr = 1; m_err = 1; end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 rvalid", {31'b0, h_rvalid}, {31'b0, m_rvalid});
      chk("R4 R10 rdata", h_rdata, m_rdata);
      chk("R2 doorbell", {31'b0, ctl_doorbell}, {31'b0, m_bell});
      chk("R2 ctl_cmd", ctl_cmd, m_cmd);
      chk("R6 host_irq", {31'b0, host_irq}, {31'b0, m_hirq});
      chk("R3 payload", ctl_pay_word, m_payw);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
    h_wr_en = 0; h_rd_en = 0; h_rd_byte = 0;
    ctl_rsp_we = 0; ctl_done = 0; ctl_err = 0;
  endtask

  task automatic hwrite(int addr, logic [31:0] d);
    h_wr_en = 1; h_addr = 8'(addr); h_wdata = d; tick();
  endtask

  task automatic hread_expect(int addr, bit byte_rd, logic [31:0] exp, string tag);
    h_rd_en = 1; h_addr = 8'(addr); h_rd_byte = byte_rd; tick();
    chk(tag, h_rdata, exp);
  endtask

  task automatic rsp_write(int idx, logic [31:0] d);
    ctl_rsp_we = 1; ctl_rsp_idx = 2'(idx); ctl_rsp_word = d; tick();
  endtask

  task automatic finish_cmd(bit e, logic [7:0] code, logic [7:0] init);
    ctl_done = 1; ctl_err = e; ctl_err_code = code; ctl_init_id = init; tick();
  endtask

  bit done_flag = 0;

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    tick();
    // R1: reset state
    chk("R1 doorbell", {31'b0, ctl_doorbell}, 32'h0);
    chk("R1 host_irq", {31'b0, host_irq}, 32'h0);
    hread_expect('h04, 0, 32'h0, "R1 status");

    // R3: payload words, controller walks the indices
    for (int k = 0; k < 4; k++) hwrite('h80 + 4 * k, 32'h1111_0000 * (k + 1) + k);
    for (int k = 0; k < 4; k++) begin ctl_pay_idx = 2'(3 - k); tick(); end
    tick();
    chk("R3 payload word 0", ctl_pay_word, 32'h1111_0000);

    // R2: accepted command with interrupt-on-completion, id 1
    hwrite('h00, 32'h0008_11FF);
    hread_expect('h04, 0, 32'h0000_0011, "R2 status busy id");

    // R8: refused second command
    hwrite('h00, 32'h0004_20AA);
    chk("R8 ctl_cmd kept", ctl_cmd, 32'h0008_11FF);
    hread_expect('h04, 0, 32'h0000_0013, "R8 status overrun");

    // R4 answer words, R5 R6 completion
    rsp_write(0, 32'hA1B2_C3D4);
    rsp_write(1, 32'h0102_0304);
    rsp_write(2, 32'hDEAD_BEEF);
    rsp_write(3, 32'h5566_7788);
    finish_cmd(0, 8'h5A, 8'h3C);
    hread_expect('h04, 0, 32'h005A_3C16, "R5 R6 R8 status after done");

    hread_expect('h90, 0, 32'hA1B2_C3D4, "R4 word 0");
    hread_expect('h91, 1, 32'h0000_00C3, "R4 byte 1");
    hread_expect('h93, 1, 32'h0000_00A1, "R4 byte 3");
    hread_expect('h98, 1, 32'h0000_00EF, "R4 byte 8");
    hread_expect('h9C, 0, 32'h5566_7788, "R4 word 3");

    // R7: write with bit 2 clear keeps the flag, bit 2 set clears it
    hwrite('h04, 32'hFFFF_FFFB);
    hread_expect('h04, 0, 32'h005A_3C16, "R7 flag kept");
    hwrite('h04, 32'h0000_0004);
    hread_expect('h04, 0, 32'h005A_3C12, "R7 flag cleared");

    // R9: done while idle
    finish_cmd(1, 8'h77, 8'h99);
    chk("R9 no host_irq", {31'b0, host_irq}, 32'h0);
    hread_expect('h04, 0, 32'h005A_3C12, "R9 status unchanged");

    // R2 R6: command without interrupt-on-completion
    hwrite('h00, 32'h0000_2010);
    hread_expect('h04, 0, 32'h005A_3C21, "R2 second accept");
    finish_cmd(1, 8'hE1, 8'h07);
    chk("R6 no pulse", {31'b0, host_irq}, 32'h0);
    hread_expect('h04, 0, 32'h00E1_0722, "R5 R6 error no flag");

    // R7: completion sets the flag in the same cycle as a host clear
    hwrite('h00, 32'h0000_3155);
    h_wr_en = 1; h_addr = 8'h04; h_wdata = 32'h4;
    ctl_done = 1; ctl_err = 0; ctl_err_code = 8'h00; ctl_init_id = 8'h11;
    tick();
    chk("R6 pulse", {31'b0, host_irq}, 32'h1);
    hread_expect('h04, 0, 32'h0000_1134, "R7 set wins");

    // R8: refused command in the same cycle as completion
    hwrite('h04, 32'h4);
    hwrite('h00, 32'h0000_4000);
    h_wr_en = 1; h_addr = 8'h00; h_wdata = 32'h0000_5000;
    ctl_done = 1; ctl_err = 0; ctl_err_code = 8'h22; ctl_init_id = 8'h33;
    tick();
    chk("R8 cmd kept at completion", ctl_cmd, 32'h0000_4000);
    hread_expect('h04, 0, 32'h0022_3342, "R8 error through completion");

    // R10: write-only and unmapped offsets read as zero
    hread_expect('h00, 0, 32'h0, "R10 cmd offset");
    hread_expect('h80, 0, 32'h0, "R10 write buffer offset");
    hread_expect('h40, 0, 32'h0, "R10 unmapped");
    tick();
    chk("R10 idle rdata", h_rdata, 32'h0);

    repeat (3) tick();
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule